// File: doc/BRIEF.md
# Page Recolor Translation Table

This block keeps a record of recent page recolorings next to the last-level cache controller. Each record binds a process identifier and a virtual page number to a physical page number and the new color that page was given inside the processor. The table is fully associative and searchable in two directions. A forward search by process and virtual page serves TLB misses before any page-table walk is started. A reverse search by physical page serves coherence requests arriving from off-chip, so they can be renamed to their on-chip alias. A third request type inserts a new recoloring, or refreshes an existing one.

One request is accepted per cycle. Reverse searches take precedence over forward searches, and forward searches take precedence over inserts. Lookups answer one cycle after acceptance. When an insert finds the table full, the least recently used record is overwritten and its old contents are raised on an eviction notice. The notice is held until acknowledged, so that a downstream agent can invalidate cached blocks and TLB copies of that alias. No further insert is accepted while the notice is pending.

Top module: `recolor_xlat_table`

## Requirements
- R1: After reset the table is empty: no response or eviction notice is pending, `ins_ready` is 1, and any lookup misses.
- R2: A reverse request is always accepted; `fwd_ready` is 0 whenever `rev_valid` is 1; `ins_ready` is 0 whenever `rev_valid` or `fwd_valid` is 1. A request not accepted has no effect on the table.
- R3: An accepted forward lookup gives `rsp_valid`=1 and `rsp_rev`=0 in the next cycle; it hits only when both process identifier and virtual page match a stored record, and then returns that record's physical page and color.
- R4: An accepted reverse lookup gives `rsp_valid`=1 and `rsp_rev`=1 in the next cycle; it hits when the physical page matches a stored record and returns that record's process identifier, virtual page and color.
- R5: On a lookup miss `rsp_hit` is 0 and `rsp_pid`, `rsp_vpn`, `rsp_ppn` and `rsp_clr` are all zero.
- R6: An insert of a new key into a table with a free slot raises no eviction notice, and the record is found by both lookups from the next cycle.
- R7: An insert whose process identifier and virtual page already exist replaces that record's physical page and color in place and raises no eviction notice.
- R8: An insert of a new key into a full table overwrites the least recently used record; from the next cycle `evn_valid` is 1 with that record's old four fields, and the old key no longer hits.
- R9: Every forward or reverse hit, and every insert, makes the touched record the most recently used.
- R10: A pending eviction notice keeps its fields stable until `evn_ack` is 1, then clears in the next cycle; while it is pending `ins_ready` is 0 and an offered insert leaves the table unchanged.
- R11: `rsp_valid` is 1 only in the cycle after an accepted lookup; inserts and idle cycles produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rev_valid | input | 1 | Reverse lookup request |
| rev_ppn | input | PPN_W | Physical page to search for |
| fwd_valid | input | 1 | Forward lookup request |
| fwd_ready | output | 1 | Forward request accepted this cycle |
| fwd_pid | input | PID_W | Process identifier to search for |
| fwd_vpn | input | VPN_W | Virtual page to search for |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert accepted this cycle |
| ins_pid | input | PID_W | Process identifier of new record |
| ins_vpn | input | VPN_W | Virtual page of new record |
| ins_ppn | input | PPN_W | Physical page of new record |
| ins_clr | input | CLR_W | New color of the page |
| rsp_valid | output | 1 | Lookup response present |
| rsp_rev | output | 1 | 1 for a reverse response, 0 for a forward one |
| rsp_hit | output | 1 | Lookup found a record |
| rsp_pid | output | PID_W | Process identifier of the hit record |
| rsp_vpn | output | VPN_W | Virtual page of the hit record |
| rsp_ppn | output | PPN_W | Physical page of the hit record |
| rsp_clr | output | CLR_W | New color of the hit record |
| evn_valid | output | 1 | Eviction notice pending |
| evn_ack | input | 1 | Eviction notice consumed |
| evn_pid | output | PID_W | Evicted process identifier |
| evn_vpn | output | VPN_W | Evicted virtual page |
| evn_ppn | output | PPN_W | Evicted physical page |
| evn_clr | output | CLR_W | Evicted color |

## Verification
A corrupted valid bit or stored field shows at the ports on the very next lookup of that key, as a wrong hit flag or wrong returned fields one cycle after acceptance. A wrong recency order stays hidden until the table is full and an insert misses, at which point the wrong record appears on the eviction notice in the following cycle and the record that should have gone keeps hitting. The bench therefore fills a small table, reorders recency through both lookup directions, and then forces an eviction to expose the order.

// File: rtl/recolor_pkg.sv
package recolor_pkg;
  // Request granted in a cycle, in descending priority.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_REV  = 2'd1,
    OP_FWD  = 2'd2,
    OP_INS  = 2'd3
  } op_e;
endpackage

// File: rtl/recolor_match.sv
// Parallel key compare across every slot, for both search directions.
module recolor_match #(
  parameter int DEPTH = 32,
  parameter int PID_W = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic [DEPTH-1:0] slot_vld,
  input  logic [PID_W-1:0] slot_pid [DEPTH],
  input  logic [VPN_W-1:0] slot_vpn [DEPTH],
  input  logic [PPN_W-1:0] slot_ppn [DEPTH],
  input  logic [PID_W-1:0] key_pid,
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [PPN_W-1:0] key_ppn,
  output logic [DEPTH-1:0] pv_hit,
  output logic [DEPTH-1:0] pp_hit
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign pv_hit[g] = slot_vld[g] && (slot_pid[g] == key_pid) && (slot_vpn[g] == key_vpn);
    assign pp_hit[g] = slot_vld[g] && (slot_ppn[g] == key_ppn);
  end
endmodule

// File: rtl/recolor_lru.sv
// Age-rank recency tracker: ages form a permutation of 0..DEPTH-1, rank 0 is newest.
module recolor_lru #(
  parameter int DEPTH = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  logic [IW-1:0] age_q [DEPTH];
  logic [IW-1:0] age_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (IW'(i) == touch_idx)            age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (age_q[i] == IW'(DEPTH - 1)) victim_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= age_d[i];
    end
  end
endmodule

// File: rtl/recolor_xlat_table.sv
module recolor_xlat_table
  import recolor_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PID_W = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int CLR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rev_valid,
  input  logic [PPN_W-1:0] rev_ppn,
  input  logic             fwd_valid,
  output logic             fwd_ready,
  input  logic [PID_W-1:0] fwd_pid,
  input  logic [VPN_W-1:0] fwd_vpn,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [PID_W-1:0] ins_pid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [CLR_W-1:0] ins_clr,
  output logic             rsp_valid,
  output logic             rsp_rev,
  output logic             rsp_hit,
  output logic [PID_W-1:0] rsp_pid,
  output logic [VPN_W-1:0] rsp_vpn,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic [CLR_W-1:0] rsp_clr,
  output logic             evn_valid,
  input  logic             evn_ack,
  output logic [PID_W-1:0] evn_pid,
  output logic [VPN_W-1:0] evn_vpn,
  output logic [PPN_W-1:0] evn_ppn,
  output logic [CLR_W-1:0] evn_clr
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Slot storage: valid bits reset, payload written only under enable.
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PID_W-1:0] pid_q [DEPTH];
  logic [VPN_W-1:0] vpn_q [DEPTH];
  logic [PPN_W-1:0] ppn_q [DEPTH];
  logic [CLR_W-1:0] clr_q [DEPTH];

  op_e              op;
  logic [PID_W-1:0] key_pid;
  logic [VPN_W-1:0] key_vpn;
  logic [DEPTH-1:0] pv_hit, pp_hit, sel_hit;
  logic             any_hit, free_any, is_look, is_ins, do_evict, touch_en;
  logic [IW-1:0]    hit_idx, free_idx, tgt_idx, touch_idx, victim_idx;

  logic             evn_vld_q, evn_vld_d;
  logic             rsp_vld_d, rsp_rev_d, rsp_hit_d;
  logic [PID_W-1:0] rsp_pid_d;
  logic [VPN_W-1:0] rsp_vpn_d;
  logic [PPN_W-1:0] rsp_ppn_d;
  logic [CLR_W-1:0] rsp_clr_d;

  // Fixed-priority arbitration: reverse, forward, insert.
  always_comb begin
    if (rev_valid)                   op = OP_REV;
    else if (fwd_valid)              op = OP_FWD;
    else if (ins_valid && !evn_vld_q) op = OP_INS;
    else                             op = OP_NONE;
  end

  assign fwd_ready = !rev_valid;
  assign ins_ready = !rev_valid && !fwd_valid && !evn_vld_q;
  assign is_look   = (op == OP_REV) || (op == OP_FWD);
  assign is_ins    = (op == OP_INS);
  assign key_pid   = is_ins ? ins_pid : fwd_pid;
  assign key_vpn   = is_ins ? ins_vpn : fwd_vpn;

  recolor_match #(
    .DEPTH(DEPTH), .PID_W(PID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_match (
    .slot_vld (vld_q),
    .slot_pid (pid_q),
    .slot_vpn (vpn_q),
    .slot_ppn (ppn_q),
    .key_pid  (key_pid),
    .key_vpn  (key_vpn),
    .key_ppn  (rev_ppn),
    .pv_hit   (pv_hit),
    .pp_hit   (pp_hit)
  );

  recolor_lru #(.DEPTH(DEPTH)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  // Lowest-index hit and lowest-index free slot.
  always_comb begin
    sel_hit  = (op == OP_REV) ? pp_hit : pv_hit;
    any_hit  = |sel_hit;
    free_any = !(&vld_q);
    hit_idx  = '0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (sel_hit[i]) hit_idx  = IW'(i);
      if (!vld_q[i])  free_idx = IW'(i);
    end
  end

  // Insert target: existing key, else free slot, else oldest record.
  always_comb begin
    tgt_idx   = any_hit ? hit_idx : (free_any ? free_idx : victim_idx);
    do_evict  = is_ins && !any_hit && !free_any;
    touch_en  = is_ins || (is_look && any_hit);
    touch_idx = is_ins ? tgt_idx : hit_idx;
    vld_d     = vld_q;
    if (is_ins) vld_d[tgt_idx] = 1'b1;
  end

  // Response next state.
  always_comb begin
    rsp_vld_d = is_look;
    rsp_rev_d = (op == OP_REV);
    rsp_hit_d = is_look && any_hit;
    rsp_pid_d = rsp_hit_d ? pid_q[hit_idx] : '0;
    rsp_vpn_d = rsp_hit_d ? vpn_q[hit_idx] : '0;
    rsp_ppn_d = rsp_hit_d ? ppn_q[hit_idx] : '0;
    rsp_clr_d = rsp_hit_d ? clr_q[hit_idx] : '0;
  end

  // Eviction notice next state.
  always_comb begin
    evn_vld_d = evn_vld_q;
    if (do_evict)     evn_vld_d = 1'b1;
    else if (evn_ack) evn_vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (is_ins) vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (is_ins) begin
      pid_q[tgt_idx] <= ins_pid;
      vpn_q[tgt_idx] <= ins_vpn;
      ppn_q[tgt_idx] <= ins_ppn;
      clr_q[tgt_idx] <= ins_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rev   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pid   <= '0;
      rsp_vpn   <= '0;
      rsp_ppn   <= '0;
      rsp_clr   <= '0;
    end else begin
      rsp_valid <= rsp_vld_d;
      rsp_rev   <= rsp_rev_d;
      rsp_hit   <= rsp_hit_d;
      rsp_pid   <= rsp_pid_d;
      rsp_vpn   <= rsp_vpn_d;
      rsp_ppn   <= rsp_ppn_d;
      rsp_clr   <= rsp_clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evn_vld_q <= 1'b0;
      evn_pid   <= '0;
      evn_vpn   <= '0;
      evn_ppn   <= '0;
      evn_clr   <= '0;
    end else begin
      evn_vld_q <= evn_vld_d;
      if (do_evict) begin
        evn_pid <= pid_q[victim_idx];
        evn_vpn <= vpn_q[victim_idx];
        evn_ppn <= ppn_q[victim_idx];
        evn_clr <= clr_q[victim_idx];
      end
    end
  end

  assign evn_valid = evn_vld_q;
endmodule

// File: rtl/recolor_xlat_checker.sv
module recolor_xlat_checker #(
  parameter int PID_W = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int CLR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rev_valid,
  input logic             fwd_valid,
  input logic             fwd_ready,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic             rsp_valid,
  input logic             rsp_rev,
  input logic             rsp_hit,
  input logic [PID_W-1:0] rsp_pid,
  input logic [VPN_W-1:0] rsp_vpn,
  input logic [PPN_W-1:0] rsp_ppn,
  input logic [CLR_W-1:0] rsp_clr,
  input logic             evn_valid,
  input logic             evn_ack,
  input logic [PID_W-1:0] evn_pid,
  input logic [VPN_W-1:0] evn_vpn,
  input logic [PPN_W-1:0] evn_ppn,
  input logic [CLR_W-1:0] evn_clr
);
  AST_REV_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rev_valid |=> rsp_valid && rsp_rev); // R2

  AST_FWD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_ready |=> rsp_valid && !rsp_rev); // R3

  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_pid == '0 && rsp_vpn == '0 && rsp_ppn == '0 && rsp_clr == '0); // R5

  AST_EVN_FROM_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evn_valid) |-> $past(ins_valid && ins_ready)); // R8

  AST_EVN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    evn_valid && !evn_ack |=> evn_valid && $stable(evn_pid) && $stable(evn_vpn)
                              && $stable(evn_ppn) && $stable(evn_clr)); // R10

  AST_EVN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    evn_valid && evn_ack |=> !evn_valid); // R10

  AST_RSP_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rev_valid || fwd_valid)); // R11

  AST_INSERT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready |=> !rsp_valid); // R11
endmodule

bind recolor_xlat_table recolor_xlat_checker #(
  .PID_W(PID_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .CLR_W(CLR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rev_valid(rev_valid), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
  .ins_valid(ins_valid), .ins_ready(ins_ready),
  .rsp_valid(rsp_valid), .rsp_rev(rsp_rev), .rsp_hit(rsp_hit),
  .rsp_pid(rsp_pid), .rsp_vpn(rsp_vpn), .rsp_ppn(rsp_ppn), .rsp_clr(rsp_clr),
  .evn_valid(evn_valid), .evn_ack(evn_ack),
  .evn_pid(evn_pid), .evn_vpn(evn_vpn), .evn_ppn(evn_ppn), .evn_clr(evn_clr)
);

// File: tb/test_recolor_xlat_table.sv
`timescale 1ns/1ps
module test_recolor_xlat_table;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rev_valid, fwd_valid, ins_valid, evn_ack;
  logic        fwd_ready, ins_ready;
  logic [19:0] rev_ppn, fwd_vpn, ins_vpn, ins_ppn;
  logic [7:0]  fwd_pid, ins_pid;
  logic [5:0]  ins_clr;
  logic        rsp_valid, rsp_rev, rsp_hit, evn_valid;
  logic [7:0]  rsp_pid, evn_pid;
  logic [19:0] rsp_vpn, rsp_ppn, evn_vpn, evn_ppn;
  logic [5:0]  rsp_clr, evn_clr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  recolor_xlat_table #(.DEPTH(DEPTH)) i_recolor_xlat_table (
    .clk(clk), .rst_n(rst_n),
    .rev_valid(rev_valid), .rev_ppn(rev_ppn),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_pid(fwd_pid), .fwd_vpn(fwd_vpn),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_pid(ins_pid), .ins_vpn(ins_vpn),
    .ins_ppn(ins_ppn), .ins_clr(ins_clr),
    .rsp_valid(rsp_valid), .rsp_rev(rsp_rev), .rsp_hit(rsp_hit),
    .rsp_pid(rsp_pid), .rsp_vpn(rsp_vpn), .rsp_ppn(rsp_ppn), .rsp_clr(rsp_clr),
    .evn_valid(evn_valid), .evn_ack(evn_ack),
    .evn_pid(evn_pid), .evn_vpn(evn_vpn), .evn_ppn(evn_ppn), .evn_clr(evn_clr)
  );

  // Vector: [60:57] tag, [56:55] op (0 insert, 1 forward, 2 reverse),
  // [54:47] pid, [46:27] vpn, [26:7] ppn, [6:1] clr, [0] expected hit.
  localparam int NV = 10;
  localparam logic [60:0] VEC [NV] = '{
    {4'd6, 2'd0, 8'h01, 20'h00010, 20'h00A00, 6'd5, 1'b0},
    {4'd3, 2'd1, 8'h01, 20'h00010, 20'h00A00, 6'd5, 1'b1},
    {4'd3, 2'd1, 8'h02, 20'h00010, 20'h00000, 6'd0, 1'b0},
    {4'd4, 2'd2, 8'h01, 20'h00010, 20'h00A00, 6'd5, 1'b1},
    {4'd5, 2'd2, 8'h00, 20'h00000, 20'h00A01, 6'd0, 1'b0},
    {4'd6, 2'd0, 8'h01, 20'h00011, 20'h00A01, 6'd6, 1'b0},
    {4'd7, 2'd0, 8'h01, 20'h00010, 20'h00A02, 6'd7, 1'b0},
    {4'd7, 2'd1, 8'h01, 20'h00010, 20'h00A02, 6'd7, 1'b1},
    {4'd7, 2'd2, 8'h00, 20'h00000, 20'h00A00, 6'd0, 1'b0},
    {4'd4, 2'd2, 8'h01, 20'h00011, 20'h00A01, 6'd6, 1'b1}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    rev_valid = 0; fwd_valid = 0; ins_valid = 0; evn_ack = 0;
  endtask

  task automatic do_ins(input logic [7:0] p, input logic [19:0] v, input logic [19:0] pp, input logic [5:0] c);
    ins_valid = 1; ins_pid = p; ins_vpn = v; ins_ppn = pp; ins_clr = c;
  endtask

  task automatic do_fwd(input logic [7:0] p, input logic [19:0] v);
    fwd_valid = 1; fwd_pid = p; fwd_vpn = v;
  endtask

  task automatic do_rev(input logic [19:0] pp);
    rev_valid = 1; rev_ppn = pp;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    rev_ppn = '0; fwd_pid = '0; fwd_vpn = '0;
    ins_pid = '0; ins_vpn = '0; ins_ppn = '0; ins_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state and empty table
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    chk("R1", "evn_valid", 32'(evn_valid), 0);
    chk("R1", "ins_ready", 32'(ins_ready), 1);
    do_rev(20'h0);
    @(negedge clk); idle();
    chk("R1", "empty lookup hit", 32'(rsp_hit), 0);

    // Main function table
    for (int k = 0; k < NV; k++) begin
      logic [60:0] v;
      string t;
      v = VEC[k];
      t = tag_name(v[60:57]);
      case (v[56:55])
        2'd0: do_ins(v[54:47], v[46:27], v[26:7], v[6:1]);
        2'd1: do_fwd(v[54:47], v[46:27]);
        default: do_rev(v[26:7]);
      endcase
      @(negedge clk); idle();
      if (v[56:55] == 2'd0) begin
        chk(t, "insert response", 32'(rsp_valid), 0);     // R11
        chk(t, "insert eviction", 32'(evn_valid), 0);
      end else begin
        chk(t, "rsp_valid", 32'(rsp_valid), 1);
        chk(t, "rsp_rev", 32'(rsp_rev), 32'(v[56:55] == 2'd2));
        chk(t, "rsp_hit", 32'(rsp_hit), 32'(v[0]));
        if (!v[0]) begin
          chk("R5", "miss ppn", 32'(rsp_ppn), 0);
          chk("R5", "miss pid", 32'(rsp_pid), 0);
        end else if (v[56:55] == 2'd1) begin
          chk(t, "ppn", 32'(rsp_ppn), 32'(v[26:7]));
          chk(t, "clr", 32'(rsp_clr), 32'(v[6:1]));
        end else begin
          chk(t, "pid", 32'(rsp_pid), 32'(v[54:47]));
          chk(t, "vpn", 32'(rsp_vpn), 32'(v[46:27]));
          chk(t, "clr", 32'(rsp_clr), 32'(v[6:1]));
        end
      end
    end

    // R2: all three at once, reverse wins
    do_rev(20'h00A01); do_fwd(8'h01, 20'h00010); do_ins(8'h03, 20'h00030, 20'h00B00, 6'd1);
    #1;
    chk("R2", "fwd_ready under rev", 32'(fwd_ready), 0);
    chk("R2", "ins_ready under rev", 32'(ins_ready), 0);
    @(negedge clk); idle();
    chk("R2", "rev wins kind", 32'(rsp_rev), 1);
    chk("R4", "rev wins vpn", 32'(rsp_vpn), 32'h11);

    // R2: forward beats insert
    do_fwd(8'h01, 20'h00010); do_ins(8'h03, 20'h00030, 20'h00B00, 6'd1);
    #1;
    chk("R2", "ins_ready under fwd", 32'(ins_ready), 0);
    @(negedge clk); idle();
    chk("R2", "fwd wins kind", 32'(rsp_rev), 0);
    chk("R3", "fwd wins ppn", 32'(rsp_ppn), 32'hA02);

    // R2: blocked inserts left no record
    do_fwd(8'h03, 20'h00030);
    @(negedge clk); idle();
    chk("R2", "blocked insert absent", 32'(rsp_hit), 0);

    // R11: idle cycle gives no response
    @(negedge clk);
    chk("R11", "idle response", 32'(rsp_valid), 0);

    // R6: fill the two free slots
    do_ins(8'h01, 20'h00012, 20'h00A03, 6'd8);
    @(negedge clk); idle();
    chk("R6", "fill eviction", 32'(evn_valid), 0);
    do_ins(8'h01, 20'h00013, 20'h00A04, 6'd9);
    @(negedge clk); idle();
    chk("R6", "full eviction", 32'(evn_valid), 0);

    // R9: promote the oldest (vpn 11) so vpn 10 becomes the victim
    do_rev(20'h00A01);
    @(negedge clk); idle();
    chk("R9", "promote hit", 32'(rsp_hit), 1);

    // R8: insert into a full table
    do_ins(8'h02, 20'h00014, 20'h00A05, 6'd10);
    @(negedge clk); idle();
    chk("R8", "evn_valid", 32'(evn_valid), 1);
    chk("R8", "evn_pid", 32'(evn_pid), 32'h01);
    chk("R8", "evn_vpn", 32'(evn_vpn), 32'h10);
    chk("R8", "evn_ppn", 32'(evn_ppn), 32'hA02);
    chk("R8", "evn_clr", 32'(evn_clr), 7);
    chk("R10", "ins_ready pending", 32'(ins_ready), 0);

    // R10: insert offered while pending is ignored
    do_ins(8'h04, 20'h00040, 20'h00C00, 6'd3);
    @(negedge clk); idle();
    chk("R10", "held evn_vpn", 32'(evn_vpn), 32'h10);
    chk("R10", "held evn_valid", 32'(evn_valid), 1);
    do_fwd(8'h04, 20'h00040);
    @(negedge clk); idle();
    chk("R10", "pending insert absent", 32'(rsp_hit), 0);

    do_fwd(8'h01, 20'h00010);
    @(negedge clk); idle();
    chk("R8", "evicted key misses", 32'(rsp_hit), 0);
    do_fwd(8'h02, 20'h00014);
    @(negedge clk); idle();
    chk("R8", "new key ppn", 32'(rsp_ppn), 32'hA05);
    chk("R8", "new key clr", 32'(rsp_clr), 10);
    do_fwd(8'h01, 20'h00011);
    @(negedge clk); idle();
    chk("R9", "promoted survives", 32'(rsp_hit), 1);

    // R10: acknowledge clears the notice
    evn_ack = 1;
    @(negedge clk); idle();
    chk("R10", "evn cleared", 32'(evn_valid), 0);
    chk("R10", "ins_ready back", 32'(ins_ready), 1);

    done = 1'b1;
    report();
    $finish;
  end
endmodule